// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Unit

The unit multiplies two 32-bit operands, or their low 16-bit halves, and either overwrites or adds into a 64-bit accumulator. The accumulator is shown as separate high and low 32-bit words. A two-bit operation code selects one of four modes: narrow multiply, narrow multiply-accumulate, wide multiply and wide multiply-accumulate. A separate input selects signed or unsigned operands.

All modes share one 17x17 signed multiplier array. Wide operations are built from up to four 16-bit partial products, applied one per cycle. The number of cycles depends on the operation and on how wide the first operand really is. The caller pulses `start_i` while the unit is idle, watches `busy_o`, and reads the accumulator in the cycle where `done_o` pulses. A synchronous `clear_i` zeroes the accumulator at any time.

Top module: `mac_unit`

## Requirements
- R1: With `op_i`=2'b00 (narrow multiply), the accumulator becomes the product of `a_i[15:0]` and `b_i[15:0]`, extended to 64 bits. The extension is sign extension when `signed_i`=1 and zero extension otherwise. Bits 31:16 of both operands are ignored.
- R2: A narrow multiply completes in 1 cycle when `a_i[15:8]` equals eight copies of (`signed_i` AND `a_i[7]`), and in 2 cycles otherwise. Latency is the count of clock edges from the edge that accepts `start_i` to the edge that writes the result.
- R3: With `op_i`=2'b01 (narrow multiply-accumulate), the extended narrow product is added to the accumulator modulo 2^64. This takes one cycle more than a narrow multiply with the same operands, so 2 or 3 cycles.
- R4: With `op_i`=2'b10 (wide multiply), the 64-bit product of the full operands overwrites the accumulator. It takes 2 cycles when `a_i[31:16]` equals sixteen copies of (`signed_i` AND `a_i[15]`), and 4 cycles otherwise.
- R5: With `op_i`=2'b11 (wide multiply-accumulate), the 64-bit product is added to the accumulator modulo 2^64, with the same latency as R4.
- R6: `busy_o` is high from the cycle after an accepted start up to the cycle before the result cycle. `done_o` is high for exactly one cycle, with `busy_o` low. The accumulator changes only on the edge that raises `done_o`, or on a clear.
- R7: A `start_i` seen while `busy_o` is high is ignored. The running operation keeps its operands and timing, and no second operation follows it.
- R8: `clear_i` zeroes the whole accumulator on the next edge. When `start_i` is high in the same cycle, the start is dropped.
- R9: A clear during an operation does not abort it. A multiply-accumulate uses the accumulator value from the cycle its start was accepted. When the clear falls on the result edge, the clear wins and `done_o` still pulses.
- R10: `acc_hi_o` is accumulator bits 63:32 and `acc_lo_o` is bits 31:0. After reset the accumulator is zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 2 | Bit 1 selects wide, bit 0 selects accumulate |
| signed_i | input | 1 | Operands are two's complement when set |
| a_i | input | 32 | First operand; its width sets the latency |
| b_i | input | 32 | Second operand |
| clear_i | input | 1 | Synchronous accumulator clear |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| acc_hi_o | output | 32 | Accumulator bits 63:32 |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
Two functions can land on the same edge. A clear can meet a result write-back, and a clear can meet a start request. The bench raises `clear_i` in the cycle just before the result edge of a four-cycle operation. It expects `done_o` to pulse with a zero accumulator. It also raises `clear_i` together with `start_i` and expects the unit to stay idle with a zero accumulator. A clear in the middle of an accumulate is judged by whether the final sum still uses the accumulator value captured at acceptance.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MUL_N = 2'b00,
    OP_MAC_N = 2'b01,
    OP_MUL_W = 2'b10,
    OP_MAC_W = 2'b11
  } mac_op_e;

  function automatic logic is_wide(mac_op_e op);
    return (op == OP_MUL_W) || (op == OP_MAC_W);
  endfunction

  function automatic logic is_accum(mac_op_e op);
    return (op == OP_MAC_N) || (op == OP_MAC_W);
  endfunction

endpackage

// File: rtl/mac_sched.sv
// Partial-product schedule: operand slices and shift for each step.
module mac_sched
  import mac_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int STEP_W = 3,
  localparam int HALF_W = DATA_W / 2,
  localparam int QRT_W  = HALF_W / 2,
  localparam int MUL_W  = HALF_W + 1,
  localparam int SH_W   = $clog2(DATA_W) + 1
) (
  input  mac_op_e             op_i,
  input  logic                sgn_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [MUL_W-1:0]    x_o,
  output logic [MUL_W-1:0]    y_o,
  output logic [SH_W-1:0]     shift_o,
  output logic [STEP_W-1:0]   n_steps_o,
  output logic                acc_step_o
);

  logic wide, accm, fast_n, short_w;
  logic [MUL_W-1:0] a_lo_s, a_lo_u, a_hi, a_ql, a_qh;
  logic [MUL_W-1:0] b_lo_s, b_lo_u, b_hi;
  logic [STEP_W-1:0] n_pp;

  always_comb begin
    wide    = is_wide(op_i);
    accm    = is_accum(op_i);
    // Upper part of A carries no information: fewer partial products
    fast_n  = (a_i[HALF_W-1:QRT_W] == {QRT_W{sgn_i & a_i[QRT_W-1]}});
    short_w = (a_i[DATA_W-1:HALF_W] == {HALF_W{sgn_i & a_i[HALF_W-1]}});

    a_lo_s = {sgn_i & a_i[HALF_W-1], a_i[HALF_W-1:0]};
    a_lo_u = {1'b0, a_i[HALF_W-1:0]};
    a_hi   = {sgn_i & a_i[DATA_W-1], a_i[DATA_W-1:HALF_W]};
    a_ql   = {{(MUL_W-QRT_W){1'b0}}, a_i[QRT_W-1:0]};
    a_qh   = {{(MUL_W-QRT_W){sgn_i & a_i[HALF_W-1]}}, a_i[HALF_W-1:QRT_W]};
    b_lo_s = {sgn_i & b_i[HALF_W-1], b_i[HALF_W-1:0]};
    b_lo_u = {1'b0, b_i[HALF_W-1:0]};
    b_hi   = {sgn_i & b_i[DATA_W-1], b_i[DATA_W-1:HALF_W]};

    if (wide) n_pp = short_w ? STEP_W'(2) : STEP_W'(4);
    else      n_pp = fast_n  ? STEP_W'(1) : STEP_W'(2);

    n_steps_o  = n_pp + STEP_W'(!wide && accm);
    acc_step_o = !wide && accm && (step_i == n_pp);

    x_o     = a_lo_s;
    y_o     = b_lo_s;
    shift_o = '0;
    if (!wide) begin
      if (!fast_n) begin
        if (step_i == '0) begin
          x_o = a_ql;
        end else begin
          x_o     = a_qh;
          shift_o = SH_W'(QRT_W);
        end
      end
    end else if (short_w) begin
      y_o = (step_i == '0) ? b_lo_u : b_hi;
      shift_o = (step_i == '0) ? '0 : SH_W'(HALF_W);
    end else begin
      unique case (step_i[1:0])
        2'd0: begin x_o = a_lo_u; y_o = b_lo_u; shift_o = '0;             end
        2'd1: begin x_o = a_lo_u; y_o = b_hi;   shift_o = SH_W'(HALF_W);  end
        2'd2: begin x_o = a_hi;   y_o = b_lo_u; shift_o = SH_W'(HALF_W);  end
        default: begin x_o = a_hi; y_o = b_hi;  shift_o = SH_W'(DATA_W);  end
      endcase
    end
  end

endmodule

// File: rtl/mac_pp_mul.sv
// Signed slice multiplier; product sign-extended and placed at its weight.
module mac_pp_mul #(
  parameter int MUL_W = 17,
  parameter int ACC_W = 64,
  parameter int SH_W  = 6
) (
  input  logic [MUL_W-1:0] x_i,
  input  logic [MUL_W-1:0] y_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [ACC_W-1:0] term_o
);

  localparam int PROD_W = 2 * MUL_W;

  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  ext;

  assign prod = $signed(x_i) * $signed(y_i);

  generate
    if (ACC_W > PROD_W) begin : g_ext
      assign ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign ext = prod[ACC_W-1:0];
    end
  endgenerate

  assign term_o = ext << shift_i;

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [STEP_W-1:0] n_steps_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              launch_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o
);

  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;

  assign launch_o = start_i && !busy_q && !clear_i;
  assign last_o   = busy_q && (step_q == n_steps_i - STEP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= last_o;
      if (launch_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign step_o = step_q;

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              clear_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o
);

  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam int MUL_W  = HALF_W + 1;
  localparam int SH_W   = $clog2(DATA_W) + 1;
  localparam int STEP_W = 3;

  mac_op_e           op_new, op_q;
  logic              sgn_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [ACC_W-1:0]  base_q, sum_q, acc_q, sum_nxt, term;
  logic              launch, last, acc_step;
  logic [STEP_W-1:0] step, n_steps;
  logic [MUL_W-1:0]  x, y;
  logic [SH_W-1:0]   shift;

  assign op_new = mac_op_e'(op_i);

  mac_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .clear_i   (clear_i),
    .n_steps_i (n_steps),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .launch_o  (launch),
    .last_o    (last),
    .step_o    (step)
  );

  mac_sched #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_sched (
    .op_i       (op_q),
    .sgn_i      (sgn_q),
    .a_i        (a_q),
    .b_i        (b_q),
    .step_i     (step),
    .x_o        (x),
    .y_o        (y),
    .shift_o    (shift),
    .n_steps_o  (n_steps),
    .acc_step_o (acc_step)
  );

  mac_pp_mul #(.MUL_W(MUL_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_mul (
    .x_i     (x),
    .y_i     (y),
    .shift_i (shift),
    .term_o  (term)
  );

  // Narrow accumulate adds the snapshot in its own step
  assign sum_nxt = sum_q + (acc_step ? base_q : term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_MUL_N;
      sgn_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      base_q <= '0;
      sum_q  <= '0;
    end else if (launch) begin
      op_q   <= op_new;
      sgn_q  <= signed_i;
      a_q    <= a_i;
      b_q    <= b_i;
      base_q <= is_accum(op_new) ? acc_q : '0;
      sum_q  <= (is_accum(op_new) && is_wide(op_new)) ? acc_q : '0;
    end else if (busy_o) begin
      sum_q  <= sum_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (last)    acc_q <= sum_nxt;
  end

  assign acc_hi_o = acc_q[ACC_W-1:DATA_W];
  assign acc_lo_o = acc_q[DATA_W-1:0];

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              clear_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] acc_hi_o,
  input logic [DATA_W-1:0] acc_lo_o
);

  localparam int MAX_LAT = 4;

  logic [2:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 3'd1;
    else             busy_run <= '0;
  end

  p_busy_done_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ends_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_acc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ($stable({acc_hi_o, acc_lo_o}) || done_o));

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ({acc_hi_o, acc_lo_o} == '0));

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && !clear_i));

  p_lat_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < 3'(MAX_LAT)));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .clear_i  (clear_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .acc_hi_o (acc_hi_o),
  .acc_lo_o (acc_lo_o)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, sgn, clr;
  logic [1:0]  op;
  logic [31:0] a, b;
  logic        busy_o, done_o;
  logic [31:0] acc_hi_o, acc_lo_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  logic [63:0] m_acc = '0;

  always #5 clk = ~clk;

  mac_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .signed_i(sgn),
    .a_i(a), .b_i(b), .clear_i(clr), .busy_o(busy_o), .done_o(done_o),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
  );

  function automatic logic [63:0] ext_n(logic [31:0] v, bit s);
    return s ? {{48{v[15]}}, v[15:0]} : {48'b0, v[15:0]};
  endfunction

  function automatic logic [63:0] ext_w(logic [31:0] v, bit s);
    return s ? {{32{v[31]}}, v} : {32'b0, v};
  endfunction

  function automatic logic [63:0] prod(logic [1:0] o, bit s, logic [31:0] x, logic [31:0] y);
    return o[1] ? ext_w(x, s) * ext_w(y, s) : ext_n(x, s) * ext_n(y, s);
  endfunction

  function automatic int exp_lat(logic [1:0] o, bit s, logic [31:0] x);
    if (o[1]) return (x[31:16] == {16{s & x[15]}}) ? 2 : 4;
    return ((x[15:8] == {8{s & x[7]}}) ? 1 : 2) + int'(o[0]);
  endfunction

  function automatic logic [31:0] gen_val();
    logic [31:0] r = $urandom;
    case ($urandom % 4)
      0: return r;
      1: return {{24{r[7]}}, r[7:0]};
      2: return {{16{r[15]}}, r[15:0]};
      default: return {16'b0, r[15:0]};
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive start at the current negedge; returns one cycle later
  task automatic launch(logic [1:0] o, bit s, logic [31:0] x, logic [31:0] y);
    op = o; sgn = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat, input int first);
    lat = first;
    while (!done_o && lat < 8) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(logic [1:0] o, bit s, logic [31:0] x, logic [31:0] y, string req);
    int lat;
    logic [63:0] exp_acc;
    exp_acc = o[0] ? m_acc + prod(o, s, x, y) : prod(o, s, x, y);
    launch(o, s, x, y);
    chk("R6", "busy after start", 64'(busy_o), 64'd1);
    wait_done(lat, 0);
    chk(req, "latency", 64'(lat), 64'(exp_lat(o, s, x)));
    chk(req, "result", {acc_hi_o, acc_lo_o}, exp_acc);
    chk("R6", "busy in done cycle", 64'(busy_o), 64'd0);
    m_acc = exp_acc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lat;
    logic [63:0] exp_acc, old;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start = 1'b0; clr = 1'b0; sgn = 1'b0; op = 2'b00; a = '0; b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "acc after reset", {acc_hi_o, acc_lo_o}, 64'd0);
    chk("R10", "busy after reset", 64'(busy_o), 64'd0);
    chk("R10", "done after reset", 64'(done_o), 64'd0);

    // R1 R2 narrow multiply, fast and slow, upper bits ignored
    run_op(2'b00, 1'b0, 32'h0000_00AB, 32'h0000_1234, "R1");
    run_op(2'b00, 1'b1, 32'hFFFF_FF85, 32'h0000_7FFF, "R2");
    run_op(2'b00, 1'b1, 32'h0000_8000, 32'h0000_8000, "R2");
    run_op(2'b00, 1'b0, 32'hDEAD_FFFF, 32'hBEEF_FFFF, "R1");
    chk("R10", "high word", 64'(acc_hi_o), 64'd0);
    // R3 narrow accumulate, slow path, negative product
    run_op(2'b01, 1'b1, 32'h0000_FF00, 32'h0000_0003, "R3");
    run_op(2'b01, 1'b0, 32'h1234_0011, 32'h0000_0002, "R3");
    // R4 wide multiply, short and long
    run_op(2'b10, 1'b0, 32'h0000_FFFF, 32'hFFFF_FFFF, "R4");
    run_op(2'b10, 1'b1, 32'hFFFF_8000, 32'h8000_0000, "R4");
    run_op(2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, "R4");
    // R5 wide accumulate with 64-bit wrap
    run_op(2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    run_op(2'b11, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    run_op(2'b11, 1'b1, 32'h0000_0007, 32'hFFFF_FFFD, "R5");

    // R7 start while busy is ignored
    exp_acc = prod(2'b10, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0);
    launch(2'b10, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0);
    op = 2'b00; a = 32'd5; b = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat, 1);
    chk("R7", "latency with extra start", 64'(lat), 64'd4);
    chk("R7", "result keeps first operands", {acc_hi_o, acc_lo_o}, exp_acc);
    m_acc = exp_acc;
    @(negedge clk);
    chk("R7", "no second operation busy", 64'(busy_o), 64'd0);
    chk("R7", "no second done", 64'(done_o), 64'd0);
    chk("R7", "acc unchanged", {acc_hi_o, acc_lo_o}, exp_acc);

    // R8 clear with start in the same cycle
    op = 2'b10; sgn = 1'b0; a = 32'hFFFF_FFFF; b = 32'h3; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    chk("R8", "start dropped under clear", 64'(busy_o), 64'd0);
    chk("R8", "acc cleared", {acc_hi_o, acc_lo_o}, 64'd0);
    m_acc = '0;
    @(negedge clk);
    chk("R8", "still idle", 64'(busy_o), 64'd0);

    // R9 clear in mid-operation, accumulate uses snapshot
    run_op(2'b10, 1'b0, 32'h0001_0001, 32'h0002_0003, "R4");
    old = m_acc;
    launch(2'b11, 1'b1, 32'h8765_4321, 32'hF00D_CAFE);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8", "acc zero after mid-op clear", {acc_hi_o, acc_lo_o}, 64'd0);
    wait_done(lat, 2);
    chk("R9", "latency across clear", 64'(lat), 64'd4);
    chk("R9", "snapshot accumulate",
        {acc_hi_o, acc_lo_o}, old + prod(2'b11, 1'b1, 32'h8765_4321, 32'hF00D_CAFE));
    m_acc = {acc_hi_o, acc_lo_o};

    // R9 clear on the result edge wins, done still pulses
    @(negedge clk);
    launch(2'b10, 1'b0, 32'h00F0_0001, 32'h1111_2222);
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "done with clear on write edge", 64'(done_o), 64'd1);
    chk("R9", "clear wins over write", {acc_hi_o, acc_lo_o}, 64'd0);
    m_acc = '0;
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ro;
      bit rs;
      logic [31:0] ra, rb;
      string req;
      ro = 2'($urandom % 4);
      rs = 1'($urandom % 2);
      ra = gen_val();
      rb = gen_val();
      if ($urandom % 16 == 0) begin
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8", "random clear", {acc_hi_o, acc_lo_o}, 64'd0);
        m_acc = '0;
      end
      case (ro)
        2'b00:   req = "R1";
        2'b01:   req = "R3";
        2'b10:   req = "R4";
        default: req = "R5";
      endcase
      run_op(ro, rs, ra, rb, req);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule